// File: doc/BRIEF.md
# Shared Address/Data Bus Splitter with Read/Write Strobe Decode

This block sits between a small processor and the memory and I/O devices it talks to. The processor puts the low byte of an address on a shared address/data bus at the start of each machine cycle and uses the same wires later for data. While the address-capture input `aleIn` is high, the low address byte follows the shared bus. When `aleIn` falls, the byte is held until the next capture pulse. The held byte is joined with the high address byte, which passes straight through, to form one full address.

The block also combines the active-low read and write inputs with the memory/IO select input. From these it forms four active-low strobes: memory read, memory write, I/O read and I/O write. Only one of them is ever low at a time. The shared bus appears as separate in, out and enable ports. The block drives data toward the devices only during a processor write, and it hands device data to the processor only while a read strobe is active.

Top module: `busDemux`

## Requirements
- R1: While `rstN` is low, all four strobe outputs are high, both output enables are low, and the held low address byte is cleared to 0x00.
- R2: While `aleIn` is high, `addrOut[7:0]` equals `adIn` in the same cycle, with no clock delay.
- R3: While `aleIn` is low, `addrOut[7:0]` holds the `adIn` value sampled at the last rising clock edge at which `aleIn` was high.
- R4: `addrOut[15:8]` always equals `addrHiIn`.
- R5: `memRdN` is low exactly when `rdN` is low, `wrN` is high, `ioMIn` is low (0 means memory) and reset is released.
- R6: `memWrN` is low exactly when `wrN` is low, `rdN` is high, `ioMIn` is low and reset is released.
- R7: `ioRdN` is low exactly when `rdN` is low, `wrN` is high, `ioMIn` is high (1 means I/O) and reset is released.
- R8: `ioWrN` is low exactly when `wrN` is low, `rdN` is high, `ioMIn` is high and reset is released.
- R9: If `rdN` and `wrN` are both low, all four strobes stay high. At most one strobe is ever low.
- R10: `devDataOe` is high exactly when a write strobe (memory or I/O) is low and `aleIn` is low. `devDataOut` always equals `adIn`.
- R11: `cpuDataOe` is high exactly when a read strobe (memory or I/O) is low. `cpuDataOut` equals `devDataIn` then, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| aleIn | input | 1 | Address capture enable, high during the address phase |
| addrHiIn | input | 8 | High address byte from the processor |
| adIn | input | 8 | Shared address/data bus as driven by the processor |
| rdN | input | 1 | Processor read, active low |
| wrN | input | 1 | Processor write, active low |
| ioMIn | input | 1 | 0 = memory cycle, 1 = I/O cycle |
| devDataIn | input | 8 | Data returned by memory or I/O devices |
| addrOut | output | 16 | Full address, high byte joined with the held low byte |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| devDataOut | output | 8 | Write data toward the devices |
| devDataOe | output | 1 | Enable for driving the device data bus |
| cpuDataOut | output | 8 | Read data toward the processor |
| cpuDataOe | output | 1 | Enable for driving the shared bus back to the processor |

## Verification
The address path is tested with a capture pulse followed by a change on the shared bus while `aleIn` is low. A transparent capture shows the new bus value, while a correct hold keeps the old one. Several distinct address bytes and high bytes are also used, which exposes swapped bytes and stuck bits. The strobe decode is driven through all four read/write and memory/I/O combinations, plus the illegal case with read and write both low and an idle cycle. This tells a swapped select polarity apart from a swapped read/write pairing. A write issued while `aleIn` is still high shows whether the device-side data enable is gated by the address phase.

// File: rtl/busDemuxPkg.sv
package busDemuxPkg;
  // Active-high strobe set passed from control to datapath and top
  typedef struct packed {
    logic memRd;
    logic memWr;
    logic ioRd;
    logic ioWr;
    logic devDrive;
    logic cpuDrive;
  } strobeSet_t;
endpackage

// File: rtl/busCtrl.sv
module busCtrl
  import busDemuxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       aleIn,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       ioMIn,
  output strobeSet_t strobes
);
  logic rdOnly;
  logic wrOnly;

  // Read and write both low is treated as idle, so strobes stay exclusive
  assign rdOnly = rstN && !rdN && wrN;
  assign wrOnly = rstN && !wrN && rdN;

  always_comb begin
    strobes          = '0;
    strobes.memRd    = rdOnly && !ioMIn;
    strobes.ioRd     = rdOnly &&  ioMIn;
    strobes.memWr    = wrOnly && !ioMIn;
    strobes.ioWr     = wrOnly &&  ioMIn;
    strobes.devDrive = wrOnly && !aleIn;
    strobes.cpuDrive = rdOnly;
  end

  // R9: at most one strobe asserted
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.memRd, strobes.memWr, strobes.ioRd, strobes.ioWr}) <= 1);

  // R5 / R6: memory strobes only in a memory cycle
  a_r5_mem_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.memRd || strobes.memWr) |-> !ioMIn);

  // R7 / R8: I/O strobes only in an I/O cycle
  a_r7_io_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ioRd || strobes.ioWr) |-> ioMIn);

  // R10: device side driven only by a write outside the address phase
  a_r10_dev_drive: assert property (@(posedge clk) disable iff (!rstN)
    strobes.devDrive |-> (!wrN && !aleIn && (strobes.memWr || strobes.ioWr)));
endmodule

// File: rtl/addrPath.sv
module addrPath
  import busDemuxPkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleIn,
  input  logic [HI_W-1:0]   addrHiIn,
  input  logic [LO_W-1:0]   adIn,
  input  logic [LO_W-1:0]   devDataIn,
  input  strobeSet_t        strobes,
  output logic [ADDR_W-1:0] addrOut,
  output logic [LO_W-1:0]   devDataOut,
  output logic [LO_W-1:0]   cpuDataOut
);
  logic [LO_W-1:0] heldLo;
  logic [LO_W-1:0] curLo;

  // Capture register: loads while the address phase is open
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      heldLo <= '0;
    else if (aleIn) heldLo <= adIn;
  end

  // Transparent behaviour: bus passes through during the address phase
  assign curLo      = aleIn ? adIn : heldLo;
  assign addrOut    = {addrHiIn, curLo};
  assign devDataOut = adIn;
  assign cpuDataOut = strobes.cpuDrive ? devDataIn : '0;

  // R3: low byte steady through consecutive cycles outside the address phase
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!aleIn && $past(!aleIn)) |-> $stable(curLo));

  // R11: no read data toward the processor without a read strobe
  a_r11_cpu_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.memRd || strobes.ioRd) |-> (cpuDataOut == '0));
endmodule

// File: rtl/busDemux.sv
module busDemux
  import busDemuxPkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleIn,
  input  logic [HI_W-1:0]   addrHiIn,
  input  logic [LO_W-1:0]   adIn,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              ioMIn,
  input  logic [LO_W-1:0]   devDataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic [LO_W-1:0]   devDataOut,
  output logic              devDataOe,
  output logic [LO_W-1:0]   cpuDataOut,
  output logic              cpuDataOe
);
  strobeSet_t strobes;

  busCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .aleIn  (aleIn),
    .rdN    (rdN),
    .wrN    (wrN),
    .ioMIn  (ioMIn),
    .strobes(strobes)
  );

  addrPath #(.LO_W(LO_W), .HI_W(HI_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .aleIn     (aleIn),
    .addrHiIn  (addrHiIn),
    .adIn      (adIn),
    .devDataIn (devDataIn),
    .strobes   (strobes),
    .addrOut   (addrOut),
    .devDataOut(devDataOut),
    .cpuDataOut(cpuDataOut)
  );

  assign memRdN    = !strobes.memRd;
  assign memWrN    = !strobes.memWr;
  assign ioRdN     = !strobes.ioRd;
  assign ioWrN     = !strobes.ioWr;
  assign devDataOe = strobes.devDrive;
  assign cpuDataOe = strobes.cpuDrive;

  // R2: low address follows the bus during the address phase
  a_r2_follow: assert property (@(posedge clk) disable iff (!rstN)
    aleIn |-> (addrOut[LO_W-1:0] == adIn));

  // R4: high address byte passes through
  a_r4_high: assert property (@(posedge clk) disable iff (!rstN)
    addrOut[ADDR_W-1:LO_W] == addrHiIn);
endmodule

// File: tb/sim_busDemux.sv
module sim_busDemux;
  typedef struct packed {
    logic [15:0] addr;
    logic [3:0]  strb;   // memRdN, memWrN, ioRdN, ioWrN
    logic        devOe;
    logic [7:0]  devOut;
    logic        cpuOe;
    logic [7:0]  cpuOut;
  } obs_t;

  logic clk = 0;
  logic rstN = 0;
  logic aleIn = 0;
  logic [7:0] addrHiIn = 0;
  logic [7:0] adIn = 0;
  logic rdN = 1;
  logic wrN = 1;
  logic ioMIn = 0;
  logic [7:0] devDataIn = 0;
  logic [15:0] addrOut;
  logic memRdN, memWrN, ioRdN, ioWrN, devDataOe, cpuDataOe;
  logic [7:0] devDataOut, cpuDataOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] modelLo = 0;
  obs_t expQ[$];
  string tagQ[$];
  event sampleEv;
  bit done = 0;

  always #5 clk = ~clk;

  busDemux u0 (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .addrHiIn(addrHiIn), .adIn(adIn),
    .rdN(rdN), .wrN(wrN), .ioMIn(ioMIn), .devDataIn(devDataIn),
    .addrOut(addrOut), .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN),
    .ioWrN(ioWrN), .devDataOut(devDataOut), .devDataOe(devDataOe),
    .cpuDataOut(cpuDataOut), .cpuDataOe(cpuDataOe)
  );

  // Expected outputs from the requirements
  function automatic obs_t model(input logic r, input logic a, input logic [7:0] hi,
                                 input logic [7:0] ad, input logic rd, input logic wr,
                                 input logic io, input logic [7:0] dev, input logic [7:0] held);
    obs_t o;
    logic rOnly, wOnly;
    rOnly = r && !rd && wr;
    wOnly = r && !wr && rd;
    o.addr   = {hi, a ? ad : held};
    o.strb   = {!(rOnly && !io), !(wOnly && !io), !(rOnly && io), !(wOnly && io)};
    o.devOe  = wOnly && !a;
    o.devOut = ad;
    o.cpuOe  = rOnly;
    o.cpuOut = rOnly ? dev : 8'h00;
    return o;
  endfunction

  // Driver: apply at negedge, push expectation, then advance the capture model
  task automatic drive(input string tag, input logic r, input logic a, input logic [7:0] hi,
                       input logic [7:0] ad, input logic rd, input logic wr,
                       input logic io, input logic [7:0] dev);
    @(negedge clk);
    rstN = r; aleIn = a; addrHiIn = hi; adIn = ad;
    rdN = rd; wrN = wr; ioMIn = io; devDataIn = dev;
    if (!r) modelLo = 8'h00;
    expQ.push_back(model(r, a, hi, ad, rd, wr, io, dev, modelLo));
    tagQ.push_back(tag);
    ->sampleEv;
    @(posedge clk);
    if (!r) modelLo = 8'h00;
    else if (a) modelLo = ad;
  endtask

  // Monitor: compare shortly after inputs settle, away from the clock edge
  initial begin
    forever begin
      @(sampleEv);
      #1;
      begin
        obs_t got, exp;
        string tag;
        got = '{addrOut, {memRdN, memWrN, ioRdN, ioWrN}, devDataOe, devDataOut,
                cpuDataOe, cpuDataOut};
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        checks++;
        if (got !== exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset forces strobes idle and clears the held byte
    drive("R1 reset read attempt", 0, 0, 8'h12, 8'h55, 0, 1, 0, 8'h99);
    drive("R1 reset write attempt", 0, 0, 8'h12, 8'h55, 1, 0, 1, 8'h99);
    // R2: follow during address phase
    drive("R2 follow 3C", 1, 1, 8'h40, 8'h3C, 1, 1, 0, 8'h00);
    drive("R2 follow C3", 1, 1, 8'h40, 8'hC3, 1, 1, 0, 8'h00);
    // R3 + R5 + R11: held byte, memory read
    drive("R3 R5 R11 mem read", 1, 0, 8'h40, 8'hA5, 0, 1, 0, 8'h77);
    drive("R3 hold with bus change", 1, 0, 8'h41, 8'h5A, 1, 1, 0, 8'h77);
    // R6 + R10: memory write
    drive("R6 R10 mem write", 1, 0, 8'h41, 8'hE1, 1, 0, 0, 8'h00);
    // R7 + R11: I/O read
    drive("R7 R11 io read", 1, 0, 8'h00, 8'h2B, 0, 1, 1, 8'hB4);
    // R8 + R10: I/O write
    drive("R8 R10 io write", 1, 0, 8'h00, 8'h6D, 1, 0, 1, 8'h11);
    // R9: illegal read+write together
    drive("R9 both low mem", 1, 0, 8'h22, 8'h0F, 0, 0, 0, 8'h33);
    drive("R9 both low io", 1, 0, 8'h22, 8'h0F, 0, 0, 1, 8'h33);
    // R10: write during address phase does not drive devices
    drive("R10 write in addr phase", 1, 1, 8'h7E, 8'h81, 1, 0, 0, 8'h00);
    drive("R10 write after capture", 1, 0, 8'h7E, 8'h99, 1, 0, 0, 8'h00);
    // R4 + R2/R3 over several bytes
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = 8'(8'h1F * (i + 1) ^ 8'hA0);
      drive("R2 R4 capture loop", 1, 1, 8'(~b), b, 1, 1, i[0], 8'h00);
      drive("R3 R4 hold loop", 1, 0, b, 8'(b + 8'h5), 0, 1, i[0], 8'(b ^ 8'hFF));
    end
    // R11: idle gives zero read data
    drive("R11 idle", 1, 0, 8'h10, 8'h20, 1, 1, 1, 8'hEE);
    // R1: reset again clears the held byte
    drive("R1 second reset", 0, 0, 8'h10, 8'h20, 0, 1, 1, 8'hEE);
    drive("R1 held cleared", 1, 0, 8'h10, 8'h20, 1, 1, 0, 8'hEE);
    @(negedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule